// File: doc/BRIEF.md
# Receive Packet Handler

This block sits behind the demodulator of a sub-GHz receiver and turns the byte stream that follows a sync-word hit into host-visible data. Once armed, it waits for a sync-found pulse. It then optionally removes the data whitening from each byte and takes the packet length either from the leading byte or from a programmed constant. It can drop packets whose address byte does not match, and can verify a two-byte CRC trailer. After the payload it can append two status bytes that carry signal strength, link quality and the CRC verdict.

Every byte meant for the host is placed in a single-byte holding register. The host must consume it with a read strobe before the handler stores the next one. If a new byte arrives while the register is still occupied, the handler stops in an overflow state and raises both interrupt pulses. It stays there until an idle command is given. Configuration inputs are expected to stay stable while a packet is in progress.

Top module: `pkt_rx_handler`

## Requirements
- R1: After reset the state output reads 0 (idle), the data-ready output is low and both interrupt pulses are low; an arm strobe while idle moves the state to 1 (waiting for sync).
- R2: Input bytes offered while waiting for sync are ignored; a sync-found pulse in state 1 moves the state to 2 (payload) on the next clock edge.
- R3: With de-whitening enabled, each byte after sync (length, address, payload and CRC bytes) is XORed with the low 8 bits of a 9-bit LFSR. The LFSR is loaded with all ones at sync. After each byte it shifts 8 times toward bit 0, and each shift feeds bit0 XOR bit5 into bit 8. With de-whitening disabled, bytes pass unchanged.
- R4: In variable-length mode, the first byte after sync is delivered as the length L, then exactly L more bytes are delivered; L = 0 ends the payload at once.
- R5: In variable-length mode, a length byte greater than the programmed maximum delivers nothing and returns the state to 1.
- R6: In fixed-length mode, exactly the programmed number of bytes (1 to 255) is delivered with no length byte.
- R7: With address checking on, the first byte after the length byte (or the first byte in fixed mode) is compared with the device address; on a match it is delivered, on a mismatch it is not delivered and the state returns to 1.
- R8: With CRC checking on, the two bytes after the payload are taken as a CRC (high byte first) and are not delivered. They are compared with a CRC-16 (polynomial 0x8005, initial value 0xFFFF, MSB first) taken over all delivered packet bytes, length byte included.
- R9: With status enabled, two bytes follow the payload: first the RSSI input, then a byte whose bit 7 is the CRC-OK flag (1 only when checking is on and the CRC matched) and whose bits 6:0 are the link-quality input. Each status byte is written only once the holding register is free. With status disabled, no such bytes appear.
- R10: A packet that completes returns the state to 0 and raises the done pulse for exactly one cycle.
- R11: A delivered byte sets data-ready and stays stable until a read strobe clears it; a read strobe and a new byte in the same cycle replace the old byte without overflow.
- R12: A byte to be delivered while data-ready is high and no read strobe is given is discarded, the state becomes 7 (overflow) and the done and overflow pulses rise together for one cycle; state 7 is left only by the idle strobe.
- R13: The idle strobe, from any state, returns the state to 0 on the next edge and clears data-ready; it takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_arm | input | 1 | Strobe: start waiting for sync from idle |
| idle_strobe | input | 1 | Strobe: return to idle from any state |
| sync_found | input | 1 | Pulse from the demodulator: sync word found |
| in_valid | input | 1 | A received byte is present on in_byte |
| in_byte | input | 8 | Received byte |
| cfg_whiten_en | input | 1 | Enable de-whitening |
| cfg_var_len | input | 1 | 1 = length from first byte, 0 = fixed length |
| cfg_fixed_len | input | 8 | Byte count in fixed-length mode |
| cfg_max_len | input | 8 | Largest accepted length byte |
| cfg_addr_chk | input | 1 | Enable address filtering |
| cfg_dev_addr | input | 8 | Device address |
| cfg_crc_en | input | 1 | Enable CRC trailer check |
| cfg_status_en | input | 1 | Append the two status bytes |
| rssi_in | input | 8 | Signal strength for the first status byte |
| lqi_in | input | 7 | Link quality for the second status byte |
| host_rd | input | 1 | Host consumes the holding register |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Holding register holds an unread byte |
| rx_state | output | 3 | 0 idle, 1 sync wait, 2 payload, 3 CRC, 4/5 status, 7 overflow |
| irq_done | output | 1 | One-cycle pulse: packet finished or overflow |
| irq_ovf | output | 1 | One-cycle pulse: overflow |

## Verification
The bench builds the handler with its default parameters. These include the whitening generator, which brings the de-whitening path and its LFSR stepping across the CRC trailer within reach, and a 16-bit CRC with polynomial 0x8005, so a trailer computed independently in the bench can be judged. An 8-bit length field lets the maximum-length abort and the zero-length packet both be exercised. Host reads are issued either one cycle after each byte or in the very cycle the next byte lands, which covers both the free-register path and the simultaneous read-and-write path next to the deliberate overflow.

// File: rtl/prx_pkg.sv
package prx_pkg;
   typedef enum logic [2:0] {
      PRX_IDLE     = 3'd0,
      PRX_SEARCH   = 3'd1,
      PRX_PAYLOAD  = 3'd2,
      PRX_CRC      = 3'd3,
      PRX_STAT_A   = 3'd4,
      PRX_STAT_B   = 3'd5,
      PRX_OVERFLOW = 3'd7
   } prx_state_e;
endpackage

// File: rtl/prx_whitener.sv
module prx_whitener #(
   parameter int          DATA_W = 8,
   parameter int          PN_W   = 9,
   parameter int          PN_TAP = 5,
   parameter logic [8:0]  PN_SEED = 9'h1FF,
   parameter bit          ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   output logic [DATA_W-1:0] mask
);
   if (PN_TAP >= PN_W) begin : g_bad_tap
      $error("prx_whitener: tap outside register");
   end
   if (PN_W <= DATA_W) begin : g_bad_w
      $error("prx_whitener: generator must be wider than a byte");
   end

   if (ENABLE) begin : g_pn
      logic [PN_W-1:0] s_q, s_nxt;

      always_comb begin
         s_nxt = s_q;
         for (int i = 0; i < DATA_W; i++) begin
            s_nxt = {s_nxt[0] ^ s_nxt[PN_TAP], s_nxt[PN_W-1:1]};
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       s_q <= PN_SEED[PN_W-1:0];
         else if (restart) s_q <= PN_SEED[PN_W-1:0];
         else if (advance) s_q <= s_nxt;
      end

      assign mask = s_q[DATA_W-1:0];
   end else begin : g_none
      assign mask = '0;
   end
endmodule

// File: rtl/prx_crc.sv
module prx_crc #(
   parameter int              DATA_W = 8,
   parameter int              CRC_W  = 16,
   parameter logic [15:0]     POLY   = 16'h8005,
   parameter logic [15:0]     INIT   = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              update,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc
);
   localparam logic [CRC_W-1:0] POLY_W = POLY[CRC_W-1:0];
   localparam logic [CRC_W-1:0] INIT_W = INIT[CRC_W-1:0];

   logic [CRC_W-1:0] c_q, c_nxt;

   always_comb begin
      c_nxt = c_q;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         if (c_nxt[CRC_W-1] ^ din[i]) c_nxt = {c_nxt[CRC_W-2:0], 1'b0} ^ POLY_W;
         else                         c_nxt = {c_nxt[CRC_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       c_q <= INIT_W;
      else if (restart) c_q <= INIT_W;
      else if (update)  c_q <= c_nxt;
   end

   assign crc = c_q;
endmodule

// File: rtl/prx_holdreg.sv
module prx_holdreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   output logic [DATA_W-1:0] q,
   output logic              full,
   output logic              ovf
);
   logic [DATA_W-1:0] q_q;
   logic              full_q;

   assign ovf  = wr && full_q && !rd && !clr;
   assign q    = q_q;
   assign full = full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q    <= '0;
         full_q <= 1'b0;
      end else if (clr) begin
         full_q <= 1'b0;
      end else if (wr && !ovf) begin
         q_q    <= wdata;
         full_q <= 1'b1;
      end else if (rd) begin
         full_q <= 1'b0;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !rd && !clr) |=> (full_q && $stable(q_q))); // R11
   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && rd && !wr && !clr) |=> !full_q); // R11
endmodule

// File: rtl/pkt_rx_handler.sv
module pkt_rx_handler #(
   parameter int          DATA_W         = 8,
   parameter int          CRC_W          = 16,
   parameter logic [15:0] CRC_POLY       = 16'h8005,
   parameter logic [15:0] CRC_INIT       = 16'hFFFF,
   parameter bit          WHITEN_SUPPORT = 1'b1,
   parameter int          PN_W           = 9,
   parameter int          PN_TAP         = 5,
   parameter logic [8:0]  PN_SEED        = 9'h1FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_arm,
   input  logic              idle_strobe,
   input  logic              sync_found,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic              cfg_whiten_en,
   input  logic              cfg_var_len,
   input  logic [7:0]        cfg_fixed_len,
   input  logic [7:0]        cfg_max_len,
   input  logic              cfg_addr_chk,
   input  logic [7:0]        cfg_dev_addr,
   input  logic              cfg_crc_en,
   input  logic              cfg_status_en,
   input  logic [7:0]        rssi_in,
   input  logic [6:0]        lqi_in,
   input  logic              host_rd,
   output logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic [2:0]        rx_state,
   output logic              irq_done,
   output logic              irq_ovf
);
   import prx_pkg::*;

   localparam int LQI_W = DATA_W - 1;

   if (DATA_W != 8) begin : g_bad_dw
      $error("pkt_rx_handler: byte width must be 8");
   end
   if (CRC_W != 2 * DATA_W) begin : g_bad_crc
      $error("pkt_rx_handler: CRC must span two bytes");
   end

   prx_state_e        st_q, st_d, st_n;
   logic [DATA_W-1:0] rem_q, rem_d;
   logic              need_len_q, need_len_d;
   logic              addr_pend_q, addr_pend_d;
   logic              crc_cnt_q, crc_cnt_d;
   logic [DATA_W-1:0] crc_hi_q, crc_hi_d;
   logic              crc_ok_q, crc_ok_d;
   logic              done_q, ovf_q;

   logic [DATA_W-1:0] wmask, dw, wdata;
   logic [CRC_W-1:0]  crc_val;
   logic              wr, restart, adv, crc_upd, done_d, hold_ovf, hold_full;
   prx_state_e        fin_st;
   logic              fin_done;

   prx_whitener #(
      .DATA_W(DATA_W), .PN_W(PN_W), .PN_TAP(PN_TAP), .PN_SEED(PN_SEED), .ENABLE(WHITEN_SUPPORT)
   ) u_whiten (
      .clk(clk), .rst_n(rst_n), .restart(restart), .advance(adv), .mask(wmask)
   );

   prx_crc #(
      .DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)
   ) u_crc (
      .clk(clk), .rst_n(rst_n), .restart(restart), .update(crc_upd), .din(dw), .crc(crc_val)
   );

   prx_holdreg #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(idle_strobe), .wr(wr && !idle_strobe), .wdata(wdata),
      .rd(host_rd), .q(rx_data), .full(hold_full), .ovf(hold_ovf)
   );

   assign dw       = in_byte ^ (cfg_whiten_en ? wmask : '0);
   assign fin_st   = cfg_crc_en ? PRX_CRC : (cfg_status_en ? PRX_STAT_A : PRX_IDLE);
   assign fin_done = !cfg_crc_en && !cfg_status_en;

   always_comb begin
      st_d        = st_q;
      rem_d       = rem_q;
      need_len_d  = need_len_q;
      addr_pend_d = addr_pend_q;
      crc_cnt_d   = crc_cnt_q;
      crc_hi_d    = crc_hi_q;
      crc_ok_d    = crc_ok_q;
      wr          = 1'b0;
      wdata       = dw;
      restart     = 1'b0;
      adv         = 1'b0;
      crc_upd     = 1'b0;
      done_d      = 1'b0;
      unique case (st_q)
         PRX_IDLE: if (rx_arm) st_d = PRX_SEARCH;
         PRX_SEARCH: if (sync_found) begin
            restart     = 1'b1;
            st_d        = PRX_PAYLOAD;
            need_len_d  = cfg_var_len;
            rem_d       = cfg_fixed_len;
            addr_pend_d = cfg_addr_chk;
            crc_cnt_d   = 1'b0;
            crc_ok_d    = 1'b0;
         end
         PRX_PAYLOAD: if (in_valid) begin
            adv = 1'b1;
            if (need_len_q) begin
               if (dw > cfg_max_len) begin
                  st_d = PRX_SEARCH;
               end else begin
                  wr         = 1'b1;
                  crc_upd    = 1'b1;
                  need_len_d = 1'b0;
                  rem_d      = dw;
                  if (dw == '0) begin
                     st_d   = fin_st;
                     done_d = fin_done;
                  end
               end
            end else if (addr_pend_q && (dw != cfg_dev_addr)) begin
               st_d = PRX_SEARCH;
            end else begin
               wr          = 1'b1;
               crc_upd     = 1'b1;
               addr_pend_d = 1'b0;
               rem_d       = rem_q - 1'b1;
               if (rem_q == DATA_W'(1)) begin
                  st_d   = fin_st;
                  done_d = fin_done;
               end
            end
         end
         PRX_CRC: if (in_valid) begin
            adv = 1'b1;
            if (!crc_cnt_q) begin
               crc_hi_d  = dw;
               crc_cnt_d = 1'b1;
            end else begin
               crc_ok_d = ({crc_hi_q, dw} == crc_val);
               st_d     = cfg_status_en ? PRX_STAT_A : PRX_IDLE;
               done_d   = !cfg_status_en;
            end
         end
         PRX_STAT_A: if (!hold_full || host_rd) begin
            wr    = 1'b1;
            wdata = rssi_in;
            st_d  = PRX_STAT_B;
         end
         PRX_STAT_B: if (!hold_full || host_rd) begin
            wr     = 1'b1;
            wdata  = {crc_ok_q, lqi_in[LQI_W-1:0]};
            st_d   = PRX_IDLE;
            done_d = 1'b1;
         end
         PRX_OVERFLOW: st_d = PRX_OVERFLOW;
         default: st_d = PRX_IDLE;
      endcase
   end

   always_comb begin
      if (idle_strobe)   st_n = PRX_IDLE;
      else if (hold_ovf) st_n = PRX_OVERFLOW;
      else               st_n = st_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= PRX_IDLE;
         rem_q       <= '0;
         need_len_q  <= 1'b0;
         addr_pend_q <= 1'b0;
         crc_cnt_q   <= 1'b0;
         crc_hi_q    <= '0;
         crc_ok_q    <= 1'b0;
         done_q      <= 1'b0;
         ovf_q       <= 1'b0;
      end else begin
         st_q        <= st_n;
         rem_q       <= rem_d;
         need_len_q  <= need_len_d;
         addr_pend_q <= addr_pend_d;
         crc_cnt_q   <= crc_cnt_d;
         crc_hi_q    <= crc_hi_d;
         crc_ok_q    <= crc_ok_d;
         done_q      <= !idle_strobe && (done_d || hold_ovf);
         ovf_q       <= hold_ovf;
      end
   end

   assign rx_state = st_q;
   assign rx_ready = hold_full;
   assign irq_done = done_q;
   assign irq_ovf  = ovf_q;

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PRX_OVERFLOW && !idle_strobe) |=> (st_q == PRX_OVERFLOW)); // R12
   AST_OVF_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf |-> irq_done); // R12
   AST_IDLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      idle_strobe |=> (st_q == PRX_IDLE && !rx_ready)); // R13
   AST_SYNC_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PRX_SEARCH && !sync_found && !idle_strobe) |=> (st_q == PRX_SEARCH)); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_done && !irq_ovf) |-> (st_q == PRX_IDLE)); // R10
endmodule

// File: tb/pkt_rx_handler_test.sv
module pkt_rx_handler_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_arm = 1'b0, idle_strobe = 1'b0, sync_found = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = '0;
   logic       cfg_whiten_en = 1'b0, cfg_var_len = 1'b1;
   logic [7:0] cfg_fixed_len = 8'd3, cfg_max_len = 8'd10, cfg_dev_addr = 8'h5A;
   logic       cfg_addr_chk = 1'b1, cfg_crc_en = 1'b1, cfg_status_en = 1'b1;
   logic [7:0] rssi_in = 8'hC4;
   logic [6:0] lqi_in = 7'h2B;
   logic       host_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready, irq_done, irq_ovf;
   logic [2:0] rx_state;

   int n_chk = 0, n_fail = 0, done_cnt = 0;
   bit mon_en = 1'b1;
   string cur_req = "R4";
   logic [7:0] exp_q[$];
   logic [7:0] body_q[$];

   always #5 clk = ~clk;

   pkt_rx_handler uut (
      .clk(clk), .rst_n(rst_n), .rx_arm(rx_arm), .idle_strobe(idle_strobe),
      .sync_found(sync_found), .in_valid(in_valid), .in_byte(in_byte),
      .cfg_whiten_en(cfg_whiten_en), .cfg_var_len(cfg_var_len), .cfg_fixed_len(cfg_fixed_len),
      .cfg_max_len(cfg_max_len), .cfg_addr_chk(cfg_addr_chk), .cfg_dev_addr(cfg_dev_addr),
      .cfg_crc_en(cfg_crc_en), .cfg_status_en(cfg_status_en), .rssi_in(rssi_in),
      .lqi_in(lqi_in), .host_rd(host_rd), .rx_data(rx_data), .rx_ready(rx_ready),
      .rx_state(rx_state), .irq_done(irq_done), .irq_ovf(irq_ovf)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h8005;
         else              r = {r[14:0], 1'b0};
      end
      return r;
   endfunction

   function automatic logic [8:0] pn_byte(input logic [8:0] s);
      logic [8:0] r = s;
      for (int i = 0; i < 8; i++) r = {r[0] ^ r[5], r[8:1]};
      return r;
   endfunction

   // scoreboard monitor: reads the holding register and compares with the queue
   always @(negedge clk) begin
      host_rd = 1'b0;
      if (rst_n && irq_done) done_cnt++;
      if (mon_en && rst_n && rx_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, cur_req, {24'h0, rx_data}, 32'hFFFF_FFFF);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(rx_data == e, cur_req, {24'h0, rx_data}, {24'h0, e});
         end
         host_rd = 1'b1;
      end
   end

   task automatic send_byte(input logic [7:0] b);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic pulse_sync;
      sync_found = 1'b1;
      @(negedge clk);
      sync_found = 1'b0;
   endtask

   task automatic arm;
      rx_arm = 1'b1;
      @(negedge clk);
      rx_arm = 1'b0;
   endtask

   task automatic wait_idle;
      for (int i = 0; i < 300; i++) begin
         if (rx_state == 3'd0) break;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic run_pkt(input string req, input bit crc_good, input int gap);
      logic [7:0]  plain[$];
      logic [7:0]  tx[$];
      logic [15:0] c = 16'hFFFF;
      logic [8:0]  s = 9'h1FF;
      int d0;
      cur_req = req;
      if (cfg_var_len) plain.push_back(8'(body_q.size()));
      for (int i = 0; i < body_q.size(); i++) plain.push_back(body_q[i]);
      for (int i = 0; i < plain.size(); i++) c = crc_byte(c, plain[i]);
      for (int i = 0; i < plain.size(); i++) tx.push_back(plain[i]);
      if (cfg_crc_en) begin
         tx.push_back(c[15:8]);
         tx.push_back(crc_good ? c[7:0] : ~c[7:0]);
      end
      for (int i = 0; i < tx.size(); i++) begin
         if (cfg_whiten_en) tx[i] = tx[i] ^ s[7:0];
         s = pn_byte(s);
      end
      for (int i = 0; i < plain.size(); i++) exp_q.push_back(plain[i]);
      if (cfg_status_en) begin
         exp_q.push_back(rssi_in);
         exp_q.push_back({cfg_crc_en && crc_good, lqi_in});
      end
      d0 = done_cnt;
      if (rx_state == 3'd0) arm();
      pulse_sync();
      check(rx_state == 3'd2, "R2", {29'h0, rx_state}, 32'd2);
      for (int i = 0; i < tx.size(); i++) begin
         send_byte(tx[i]);
         repeat (gap) @(negedge clk);
      end
      wait_idle();
      check(exp_q.size() == 0, req, exp_q.size(), 0);
      check(done_cnt == d0 + 1, "R10", done_cnt - d0, 1);
      check(rx_state == 3'd0, "R10", {29'h0, rx_state}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(rx_state == 3'd0, "R1", {29'h0, rx_state}, 0);
      check(!rx_ready && !irq_done && !irq_ovf, "R1", {rx_ready, irq_done, irq_ovf}, 0);
      arm();
      check(rx_state == 3'd1, "R1", {29'h0, rx_state}, 1);
      // R2 bytes before sync ignored
      send_byte(8'h33);
      @(negedge clk);
      check(!rx_ready && rx_state == 3'd1, "R2", {rx_ready, rx_state}, 1);

      // R4/R7/R8/R9: variable length, address match, good CRC, status
      body_q = {8'h5A, 8'h11, 8'h22, 8'h33};
      run_pkt("R4", 1'b1, 1);
      // R8/R9: bad CRC clears the OK bit
      body_q = {8'h5A, 8'hDE, 8'hAD};
      run_pkt("R8", 1'b0, 1);
      // R3: whitening on
      cfg_whiten_en = 1'b1;
      body_q = {8'h5A, 8'h00, 8'hFF, 8'h80, 8'h01};
      run_pkt("R3", 1'b1, 1);
      cfg_whiten_en = 1'b0;
      // R4: zero length
      cfg_addr_chk = 1'b0;
      body_q = {};
      run_pkt("R4", 1'b1, 1);
      // R6/R9: fixed length, no CRC, no status
      cfg_var_len = 1'b0; cfg_crc_en = 1'b0; cfg_status_en = 1'b0;
      body_q = {8'h71, 8'h72, 8'h73};
      run_pkt("R6", 1'b1, 1);
      // R11: byte every cycle, read in the same cycle as the next write
      cfg_fixed_len = 8'd5;
      body_q = {8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4};
      run_pkt("R11", 1'b1, 0);

      // R7: address mismatch
      cfg_var_len = 1'b1; cfg_addr_chk = 1'b1; cfg_crc_en = 1'b1; cfg_status_en = 1'b1;
      cur_req = "R7";
      arm();
      pulse_sync();
      exp_q.push_back(8'h03);
      send_byte(8'h03);
      @(negedge clk);
      send_byte(8'h77);
      repeat (3) @(negedge clk);
      check(rx_state == 3'd1, "R7", {29'h0, rx_state}, 1);
      check(exp_q.size() == 0 && !rx_ready, "R7", {exp_q.size(), rx_ready}, 0);
      // R5: length above maximum
      cur_req = "R5";
      pulse_sync();
      send_byte(8'd20);
      repeat (3) @(negedge clk);
      check(rx_state == 3'd1 && !rx_ready, "R5", {rx_ready, rx_state}, 1);

      // R12: overflow
      mon_en = 1'b0;
      cfg_var_len = 1'b0; cfg_fixed_len = 8'd4; cfg_addr_chk = 1'b0;
      cfg_crc_en = 1'b0; cfg_status_en = 1'b0;
      pulse_sync();
      send_byte(8'hA1);
      send_byte(8'hB2);
      check(rx_state == 3'd7, "R12", {29'h0, rx_state}, 7);
      check(irq_ovf && irq_done, "R12", {irq_ovf, irq_done}, 2'b11);
      check(rx_data == 8'hA1, "R12", {24'h0, rx_data}, 8'hA1);
      @(negedge clk);
      check(!irq_ovf && !irq_done && rx_state == 3'd7, "R12", {irq_ovf, irq_done, rx_state}, 7);
      send_byte(8'hC3);
      check(rx_state == 3'd7 && rx_data == 8'hA1, "R12", {rx_state, rx_data}, {3'd7, 8'hA1});
      // R13: idle strobe leaves overflow
      idle_strobe = 1'b1;
      @(negedge clk);
      idle_strobe = 1'b0;
      check(rx_state == 3'd0 && !rx_ready, "R13", {rx_ready, rx_state}, 0);
      mon_en = 1'b1;
      // R13: idle strobe mid-packet
      cur_req = "R13";
      arm();
      pulse_sync();
      exp_q.push_back(8'h44);
      send_byte(8'h44);
      idle_strobe = 1'b1;
      @(negedge clk);
      idle_strobe = 1'b0;
      check(rx_state == 3'd0, "R13", {29'h0, rx_state}, 0);
      exp_q.delete();
      repeat (3) @(negedge clk);
      report();
   end
endmodule